// File: doc/BRIEF.md
# Legacy Memory Attribute Configuration Registers

This block sits in a host bridge's configuration space and keeps the programmable access attributes for the legacy memory area below one megabyte. Seven attribute bytes supply read and write enables for thirteen shadow regions. Region 0 is the BIOS area. Regions 1 to 12 are equal-size expansion windows that follow one another. The block turns the stored nibbles into per-region enable outputs, so the memory decoder downstream can steer each region to DRAM or let it pass through.

The block also holds the SMRAM control byte. From that byte and a sampled SMM-active input it works out whether the SMRAM window (base 0xA0000, 128 KiB) is visible. A read-only byte reports the installed memory in 8 MiB units. Whenever a write reaches the attribute or SMRAM bytes, or the SMM state changes, the block raises a one-cycle refresh pulse. The pulse comes in the cycle when the new outputs are already valid, so a remapping engine can resample them.

Top module: `legacy_mem_attr_regs`

## Requirements
- R1: After synchronous reset, all attribute bytes read 0x00, the SMRAM byte reads 0x02, every region enable is 0, `smram_visible` is 0 and `remap_pulse` is 0.
- R2: Configuration bytes 0x59 to 0x5F are read/write. Each byte lane is written only when its byte enable is set. Reads are combinational and return the dword at `cfg_rd_dw` (byte address = dword index × 4 + lane, with lane 0 in bits 7:0).
- R3: Region 0 takes its attributes from the high nibble of byte 0x59. Region i (1 to 12) uses byte 0x59 + (i+1)/2, taking the low nibble when i is odd and the high nibble when i is even. The low nibble of 0x59 drives nothing.
- R4: Within a region's nibble, bit 0 drives `region_rd_en[i]` and bit 1 drives `region_wr_en[i]`. Bits 3:2 of the nibble have no effect.
- R5: Byte 0x72 is the read/write SMRAM control byte. `smram_visible` is 1 when bit 6 (open) is set, or when bit 3 (enable) is set and the sampled SMM state is 1. The SMM input is sampled by one register, so its effect shows one cycle after it changes.
- R6: A write with any enabled lane at 0x59 to 0x5F or at 0x72 produces `remap_pulse` = 1 in the cycle after the write's clock edge. In that cycle the region outputs and `smram_visible` already show the new contents.
- R7: A change of `smm_active` produces `remap_pulse` = 1 in the cycle after the edge that samples the change.
- R8: Writes to any other byte have no effect on stored state or outputs and produce no pulse. Unimplemented bytes read 0x00.
- R9: Byte 0x57 reads min(RAM_MIB / 8, 255) and ignores writes.
- R10: A tracked write and an SMM change at the same edge give one pulse cycle, not two. Tracked writes on consecutive cycles keep the pulse high for the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Dword index of the write |
| cfg_wr_be | input | 4 | Byte-lane enables of the write |
| cfg_wr_data | input | 32 | Write data, lane 0 in bits 7:0 |
| cfg_rd_dw | input | 6 | Dword index for the combinational read |
| cfg_rd_data | output | 32 | Read data |
| smm_active | input | 1 | Processor is in system management mode |
| region_rd_en | output | 13 | Per-region read-to-DRAM enable |
| region_wr_en | output | 13 | Per-region write-to-DRAM enable |
| smram_visible | output | 1 | SMRAM window is visible |
| remap_pulse | output | 1 | One-cycle mapping refresh request |

## Verification
A committing write to a tracked byte and an SMM-state change can reach the pulse register at the same clock edge. The bench provokes this by driving a write to 0x5F and toggling `smm_active` on the same falling edge. It then checks three things: the pulse is high for exactly one cycle; the region bits that changed and the new SMRAM visibility are both present in that cycle; and the pulse is low again in the following cycle. Consecutive tracked writes are also driven, to show that the pulse stays high for as many cycles as there are writes.

// File: rtl/lmattr_pkg.sv
package lmattr_pkg;
    localparam int unsigned CFG_AW     = 8;
    localparam int unsigned LANES      = 4;
    localparam int unsigned DW_AW      = CFG_AW - $clog2(LANES);
    localparam int unsigned N_REGIONS  = 13;
    localparam int unsigned ATTR_BYTES = (N_REGIONS + 1) / 2;
    localparam int unsigned ATTR_IW    = $clog2(ATTR_BYTES);

    localparam logic [CFG_AW-1:0] ATTR_BASE = 8'h59;
    localparam logic [CFG_AW-1:0] ATTR_LAST = ATTR_BASE + CFG_AW'(ATTR_BYTES - 1);
    localparam logic [CFG_AW-1:0] SMRAM_OFS = 8'h72;
    localparam logic [CFG_AW-1:0] MEMSZ_OFS = 8'h57;
    localparam logic [7:0]        SMRAM_RST = 8'h02;
    localparam int unsigned       SMRAM_OPEN_BIT = 6;
    localparam int unsigned       SMRAM_EN_BIT   = 3;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } region_attr_t;

    typedef struct packed {
        logic              we;
        logic [DW_AW-1:0]  dw;
        logic [LANES-1:0]  be;
        logic [LANES*8-1:0] data;
    } cfg_wr_t;

    typedef logic [ATTR_BYTES-1:0][7:0] attr_bank_t;

    // Which attribute byte feeds region i.
    function automatic int unsigned region_byte(input int unsigned i);
        return (i + 1) / 2;
    endfunction

    // Region 0 and even regions use the upper nibble.
    function automatic bit region_upper(input int unsigned i);
        return (i % 2) == 0;
    endfunction

    function automatic region_attr_t nibble_to_attr(input logic [3:0] n);
        region_attr_t r;
        r.rd_en = n[0];
        r.wr_en = n[1];
        return r;
    endfunction

    function automatic logic [7:0] memsz_code(input int unsigned mib);
        int unsigned units;
        units = mib / 8;
        return (units > 255) ? 8'hFF : units[7:0];
    endfunction
endpackage

// File: rtl/lmattr_cfg_regfile.sv
module lmattr_cfg_regfile
    import lmattr_pkg::*;
#(
    parameter logic [7:0] MEMSZ_BYTE = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_wr_t              wr,
    input  logic [DW_AW-1:0]     rd_dw,
    output logic [LANES*8-1:0]   rd_data,
    output attr_bank_t           attr_q,
    output logic [7:0]           smram_q,
    output logic                 wr_hit
);
    function automatic bit tracked(input logic [CFG_AW-1:0] a);
        return ((a >= ATTR_BASE) && (a <= ATTR_LAST)) || (a == SMRAM_OFS);
    endfunction

    function automatic logic [7:0] byte_at(input logic [CFG_AW-1:0] a);
        logic [7:0] v;
        v = 8'h00;
        if ((a >= ATTR_BASE) && (a <= ATTR_LAST))
            v = attr_q[ATTR_IW'(a - ATTR_BASE)];
        else if (a == SMRAM_OFS)
            v = smram_q;
        else if (a == MEMSZ_OFS)
            v = MEMSZ_BYTE;
        return v;
    endfunction

    // Attribute byte storage, one register per byte.
    for (genvar k = 0; k < ATTR_BYTES; k++) begin : g_attr
        localparam logic [CFG_AW-1:0] ADDR = ATTR_BASE + CFG_AW'(k);
        localparam int unsigned       LN   = int'(ADDR[1:0]);
        always_ff @(posedge clk) begin
            if (rst)
                attr_q[k] <= 8'h00;
            else if (wr.we && wr.dw == ADDR[CFG_AW-1:2] && wr.be[LN])
                attr_q[k] <= wr.data[LN*8 +: 8];
        end
    end

    localparam int unsigned SM_LN = int'(SMRAM_OFS[1:0]);
    always_ff @(posedge clk) begin
        if (rst)
            smram_q <= SMRAM_RST;
        else if (wr.we && wr.dw == SMRAM_OFS[CFG_AW-1:2] && wr.be[SM_LN])
            smram_q <= wr.data[SM_LN*8 +: 8];
    end

    always_comb begin
        wr_hit = 1'b0;
        for (int l = 0; l < LANES; l++)
            if (wr.we && wr.be[l] && tracked({wr.dw, 2'(l)}))
                wr_hit = 1'b1;
    end

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < LANES; l++)
            rd_data[l*8 +: 8] = byte_at({rd_dw, 2'(l)});
    end

    // R8: bytes outside the tracked set leave stored state untouched
    a_r8_untouched: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ($stable(attr_q) && $stable(smram_q)));

    // R2: a lane whose enable is clear does not change its attribute byte
    a_r2_lane_masked: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.be == 4'b0000) |=> $stable(attr_q));
endmodule

// File: rtl/lmattr_region_map.sv
module lmattr_region_map
    import lmattr_pkg::*;
(
    input  attr_bank_t             attr_q,
    output logic [N_REGIONS-1:0]   rd_en,
    output logic [N_REGIONS-1:0]   wr_en
);
    for (genvar i = 0; i < N_REGIONS; i++) begin : g_region
        localparam int unsigned BYTE_IX = region_byte(i);
        localparam bit          UPPER   = region_upper(i);
        logic [3:0]   nib;
        region_attr_t ra;
        if (UPPER) begin : g_hi
            assign nib = attr_q[BYTE_IX][7:4];
        end else begin : g_lo
            assign nib = attr_q[BYTE_IX][3:0];
        end
        assign ra       = nibble_to_attr(nib);
        assign rd_en[i] = ra.rd_en;
        assign wr_en[i] = ra.wr_en;
    end
endmodule

// File: rtl/lmattr_smram_ctl.sv
module lmattr_smram_ctl
    import lmattr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smm_in,
    input  logic [7:0] smram_q,
    input  logic       wr_hit,
    output logic       visible,
    output logic       pulse
);
    logic smm_q;
    logic smm_edge;

    assign smm_edge = smm_in ^ smm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smm_q <= 1'b0;
            pulse <= 1'b0;
        end else begin
            smm_q <= smm_in;
            pulse <= wr_hit | smm_edge;
        end
    end

    assign visible = smram_q[SMRAM_OPEN_BIT] | (smm_q & smram_q[SMRAM_EN_BIT]);

    // R1: reset leaves SMRAM byte at its default and the window hidden
    a_r1_smram_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (smram_q == SMRAM_RST && !visible && !pulse));

    // R7: any SMM transition yields a refresh
    a_r7_smm_refresh: assert property (@(posedge clk) disable iff (rst)
        smm_edge |=> pulse);

    // R6: a tracked write yields a refresh
    a_r6_write_refresh: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> pulse);

    // R10: the pulse never comes without a cause one edge earlier
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(wr_hit) || $past(smm_edge)));

    // R5: window stays hidden while closed and outside SMM
    a_r5_hidden: assert property (@(posedge clk) disable iff (rst)
        (!smram_q[SMRAM_OPEN_BIT] && !smm_q) |-> !visible);
endmodule

// File: rtl/legacy_mem_attr_regs.sv
module legacy_mem_attr_regs
    import lmattr_pkg::*;
#(
    parameter int unsigned RAM_MIB = 512
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr_en,
    input  logic [DW_AW-1:0]       cfg_wr_dw,
    input  logic [LANES-1:0]       cfg_wr_be,
    input  logic [LANES*8-1:0]     cfg_wr_data,
    input  logic [DW_AW-1:0]       cfg_rd_dw,
    output logic [LANES*8-1:0]     cfg_rd_data,
    input  logic                   smm_active,
    output logic [N_REGIONS-1:0]   region_rd_en,
    output logic [N_REGIONS-1:0]   region_wr_en,
    output logic                   smram_visible,
    output logic                   remap_pulse
);
    localparam logic [7:0] MEMSZ_BYTE = memsz_code(RAM_MIB);

    cfg_wr_t    wr;
    attr_bank_t attr_q;
    logic [7:0] smram_q;
    logic       wr_hit;

    assign wr.we   = cfg_wr_en;
    assign wr.dw   = cfg_wr_dw;
    assign wr.be   = cfg_wr_be;
    assign wr.data = cfg_wr_data;

    lmattr_cfg_regfile #(.MEMSZ_BYTE(MEMSZ_BYTE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_dw   (cfg_rd_dw),
        .rd_data (cfg_rd_data),
        .attr_q  (attr_q),
        .smram_q (smram_q),
        .wr_hit  (wr_hit)
    );

    lmattr_region_map u_map (
        .attr_q (attr_q),
        .rd_en  (region_rd_en),
        .wr_en  (region_wr_en)
    );

    lmattr_smram_ctl u_smram (
        .clk     (clk),
        .rst     (rst),
        .smm_in  (smm_active),
        .smram_q (smram_q),
        .wr_hit  (wr_hit),
        .visible (smram_visible),
        .pulse   (remap_pulse)
    );

    // R6: region enables only move in a cycle that carries the refresh pulse
    a_r6_region_hold: assert property (@(posedge clk) disable iff (rst)
        !remap_pulse |-> ($stable(region_rd_en) && $stable(region_wr_en)));

    // R5: visibility only moves together with a refresh pulse
    a_r5_vis_hold: assert property (@(posedge clk) disable iff (rst)
        !remap_pulse |-> $stable(smram_visible));
endmodule

// File: tb/legacy_mem_attr_regs_bench.sv
module legacy_mem_attr_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 13;
    localparam int RAM_MIB = 512;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [5:0]  cfg_wr_dw;
    logic [3:0]  cfg_wr_be;
    logic [31:0] cfg_wr_data;
    logic [5:0]  cfg_rd_dw;
    logic [31:0] cfg_rd_data;
    logic        smm_active;
    logic [NREG-1:0] region_rd_en, region_wr_en;
    logic        smram_visible, remap_pulse;

    int checks = 0;
    int errors = 0;

    // bench model of the writable bytes
    logic [7:0] m_attr [7];
    logic [7:0] m_smram;
    logic       m_smm;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_mem_attr_regs #(.RAM_MIB(RAM_MIB)) u_legacy_mem_attr_regs (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_dw(cfg_rd_dw), .cfg_rd_data(cfg_rd_data),
        .smm_active(smm_active), .region_rd_en(region_rd_en),
        .region_wr_en(region_wr_en), .smram_visible(smram_visible),
        .remap_pulse(remap_pulse)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(input int a);
        if (a >= 'h59 && a <= 'h5F) return m_attr[a - 'h59];
        if (a == 'h72) return m_smram;
        if (a == 'h57) return (RAM_MIB / 8 > 255) ? 8'hFF : 8'(RAM_MIB / 8);
        return 8'h00;
    endfunction

    task automatic check_dword(input string req, input logic [5:0] dw);
        logic [31:0] exp;
        cfg_rd_dw = dw;
        #1;
        for (int l = 0; l < 4; l++) exp[l*8 +: 8] = model_byte(dw * 4 + l);
        check(req, $sformatf("read dword 0x%0h", dw * 4), cfg_rd_data, exp);
    endtask

    task automatic check_outputs(input string req);
        logic [NREG-1:0] er, ew;
        logic [3:0] n;
        for (int i = 0; i < NREG; i++) begin
            n = (i % 2 == 0) ? m_attr[(i + 1) / 2][7:4] : m_attr[(i + 1) / 2][3:0];
            er[i] = n[0];
            ew[i] = n[1];
        end
        check(req, "region_rd_en", 32'(region_rd_en), 32'(er));
        check(req, "region_wr_en", 32'(region_wr_en), 32'(ew));
        check(req, "smram_visible", 32'(smram_visible),
              32'(m_smram[6] | (m_smm & m_smram[3])));
    endtask

    function automatic void model_write(input logic [5:0] dw, input logic [3:0] be,
                                        input logic [31:0] d);
        for (int l = 0; l < 4; l++) begin
            int a;
            a = dw * 4 + l;
            if (be[l]) begin
                if (a >= 'h59 && a <= 'h5F) m_attr[a - 'h59] = d[l*8 +: 8];
                if (a == 'h72) m_smram = d[l*8 +: 8];
            end
        end
    endfunction

    // Drive a write on a falling edge; after the next falling edge the pulse is visible.
    task automatic cfg_write(input string req, input logic [5:0] dw, input logic [3:0] be,
                             input logic [31:0] d, input logic exp_pulse);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_be = be; cfg_wr_data = d;
        model_write(dw, be, d);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(req, "remap_pulse after write", 32'(remap_pulse), 32'(exp_pulse));
        check_outputs(req);
    endtask

    task automatic idle_pulse_low(input string req);
        @(negedge clk);
        check(req, "remap_pulse idle", 32'(remap_pulse), 32'h0);
    endtask

    task automatic t_reset;
        check("R1", "remap_pulse", 32'(remap_pulse), 32'h0);
        check_outputs("R1");
        check_dword("R1", 6'h16);
        check_dword("R1", 6'h17);
        check_dword("R1", 6'h1C);
    endtask

    task automatic t_attr_rw;
        cfg_write("R2", 6'h16, 4'b1110, 32'h31_12_2F_AA, 1'b1);
        check_dword("R2", 6'h16);
        cfg_write("R3", 6'h17, 4'b1111, 32'h13_21_03_30, 1'b1);
        check_dword("R3", 6'h17);
        check_outputs("R4");
        idle_pulse_low("R6");
    endtask

    task automatic t_partial_be;
        cfg_write("R2", 6'h17, 4'b0010, 32'hFFFF_C5FF, 1'b1);
        check_dword("R2", 6'h17);
        check_outputs("R3");
        cfg_write("R4", 6'h16, 4'b0100, 32'h00_C8_00_00, 1'b1);
        check_outputs("R4");
    endtask

    task automatic t_smram;
        cfg_write("R5", 6'h1C, 4'b0100, 32'h0040_0000, 1'b1);
        check("R5", "open window", 32'(smram_visible), 32'h1);
        check_dword("R5", 6'h1C);
        cfg_write("R5", 6'h1C, 4'b0100, 32'h0008_0000, 1'b1);
        check("R5", "enabled but outside SMM", 32'(smram_visible), 32'h0);
        @(negedge clk);
        smm_active = 1'b1; m_smm = 1'b1;
        check("R5", "SMM not yet sampled", 32'(smram_visible), 32'h0);
        @(negedge clk);
        check("R7", "remap_pulse on SMM entry", 32'(remap_pulse), 32'h1);
        check_outputs("R5");
        idle_pulse_low("R7");
        smm_active = 1'b0; m_smm = 1'b0;
        @(negedge clk);
        check("R7", "remap_pulse on SMM exit", 32'(remap_pulse), 32'h1);
        check_outputs("R5");
    endtask

    task automatic t_other_bytes;
        cfg_write("R9", 6'h15, 4'b1111, 32'hFFFF_FFFF, 1'b0);
        check_dword("R9", 6'h15);
        check("R9", "size byte value", cfg_rd_data[31:24], 32'h40);
        cfg_write("R8", 6'h18, 4'b1111, 32'hDEAD_BEEF, 1'b0);
        check_dword("R8", 6'h18);
        cfg_write("R8", 6'h16, 4'b0001, 32'h0000_00FF, 1'b0);
        check_dword("R8", 6'h16);
    endtask

    task automatic t_collide;
        // tracked write and SMM entry land on the same edge
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = 6'h17; cfg_wr_be = 4'b1000; cfg_wr_data = 32'h3300_0000;
        model_write(6'h17, 4'b1000, 32'h3300_0000);
        smm_active = 1'b1; m_smm = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check("R10", "pulse on shared edge", 32'(remap_pulse), 32'h1);
        check_outputs("R10");
        idle_pulse_low("R10");
        // consecutive tracked writes hold the pulse for two cycles
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = 6'h16; cfg_wr_be = 4'b0010; cfg_wr_data = 32'h0000_1100;
        model_write(6'h16, 4'b0010, 32'h0000_1100);
        @(negedge clk);
        check("R10", "first of back-to-back", 32'(remap_pulse), 32'h1);
        cfg_wr_dw = 6'h17; cfg_wr_be = 4'b0001; cfg_wr_data = 32'h0000_0022;
        model_write(6'h17, 4'b0001, 32'h0000_0022);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check("R10", "second of back-to-back", 32'(remap_pulse), 32'h1);
        check_outputs("R6");
        idle_pulse_low("R10");
        smm_active = 1'b0; m_smm = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_wr_en = 1'b0; cfg_wr_dw = '0; cfg_wr_be = '0; cfg_wr_data = '0;
        cfg_rd_dw = '0; smm_active = 1'b0;
        for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
        m_smram = 8'h02;
        m_smm = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_attr_rw();
        t_partial_be();
        t_smram();
        t_other_bytes();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule